// File: doc/BRIEF.md
# Serial Audio Formatter with Phase Sideband

This block turns parallel audio samples into a bit-serial stream. It generates its own bit clock and frame clock, and it places an 8-bit sideband byte inside every 32-bit channel subframe. The sideband byte carries a phase word that is shared along a chain of cascaded converters. Four framings are available: left-justified, I2S, right-justified and multi-slot TDM. The framing decides where the byte sits: in the low byte of the slot for left-justified, I2S and TDM, and in the high byte for right-justified.

A receiver inside the block watches a second serial stream in the same framing. That stream may come from a device whose frame clock has no fixed relation to this one. The receiver recovers the sideband byte at the close of each subframe. When the block is set to follow, it sends on the byte it last received and ignores its local byte. A leader device sends its own byte.

The system clock runs every flop. The outgoing bit clock has a half-period of `HALF` system clocks. Serial data and the frame clock change only as the bit clock falls. Audio is 24 bits wide and is sent MSB first.

Top module: `sbfmt_top`

## Requirements
- R1: A subframe is 32 bit-clock periods. A frame holds 2 subframes in the stereo framings and `CH` subframes in TDM. The bit clock stays at each level for `HALF` system clocks. Serial data and the frame clock change only on the cycle in which the bit clock falls.
- R2: Left-justified (`fmt_i` = 0): the frame clock is high for subframe 0 and low for subframe 1. Each subframe sends the 24-bit sample followed by the sideband byte, MSB first, with the MSB in the first bit after the frame-clock edge.
- R3: I2S (`fmt_i` = 1): the frame clock is low for subframe 0 and high for subframe 1. The subframe content is the same as in R2, but it starts one bit-clock period after the frame-clock edge.
- R4: Right-justified (`fmt_i` = 2): the subframe sends the sideband byte first and then the 24-bit sample. The sample's LSB lands on the last bit of the subframe. The frame clock behaves as in R2.
- R5: TDM (`fmt_i` = 3): the frame clock is high for exactly the first bit period of a frame. `CH` slots follow back to back. Slot k carries channel k (`samples_i` bits [24k+23:24k]) and then the sideband byte.
- R6: Format, samples and sideband byte are captured as a frame begins. A change to them during a frame has no effect on the subframes of that frame.
- R7: With `slave_i` = 1, the outgoing sideband byte is the one most recently recovered by the receiver, and `sb_i` has no effect.
- R8: At the end of every received subframe, the receiver places that subframe's sideband byte on `rx_sb_o`, taken from the position that `fmt_i` selects. `rx_valid_o` is high for exactly one system clock for each such subframe.
- R9: During reset, `sdata_o`, `fclk_o`, `bclk_o`, `rx_valid_o` and `rx_sb_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i | input | 2 | Framing: 0 left-justified, 1 I2S, 2 right-justified, 3 TDM |
| slave_i | input | 1 | 1: forward the received sideband byte instead of `sb_i` |
| sb_i | input | 8 | Local sideband byte |
| samples_i | input | CH*AW | Audio samples, channel k at bits [AW*k+AW-1:AW*k] |
| sdata_o | output | 1 | Serial data out |
| fclk_o | output | 1 | Frame clock out |
| bclk_o | output | 1 | Bit clock out |
| rx_sdata_i | input | 1 | Incoming serial data |
| rx_fclk_i | input | 1 | Incoming frame clock |
| rx_bclk_i | input | 1 | Incoming bit clock |
| rx_sb_o | output | 8 | Last recovered sideband byte |
| rx_valid_o | output | 1 | One-cycle strobe when `rx_sb_o` updates |

## Verification
The receiver checks assume that each level of the incoming bit clock lasts for at least one system clock, so that rising edges cannot merge and the valid strobe can never last two cycles. They also assume that the framing select stays fixed while the receiver is aligned to a stream. In the test, the receiver is fed by a second instance of the block. That instance runs on the same system clock with the same bit-clock divider, and its inputs change together with those of the block under test. After every format change the bench lets several frames pass before it judges anything. Inputs change in the middle of a frame in one directed case only, and that case exists to show they are ignored.

// File: rtl/sbfmt_pkg.sv
package sbfmt_pkg;
   localparam int SLOT = 32;
   localparam int SBW  = 8;

   typedef enum logic [1:0] {
      FMT_LJ  = 2'd0,
      FMT_I2S = 2'd1,
      FMT_RJ  = 2'd2,
      FMT_TDM = 2'd3
   } fmt_e;
endpackage

// File: rtl/sbfmt_bitclk.sv
module sbfmt_bitclk #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic bclk_o,
   output logic bit_start_o
);
   localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

   logic [HW-1:0] hc;
   logic          bclk_q;
   logic          turn;

   initial begin : p_param_chk
      assert (HALF >= 2) else $error("HALF must be at least 2");
   end

   assign turn = (hc == HW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc     <= '0;
         bclk_q <= 1'b0;
      end else if (turn) begin
         hc     <= '0;
         bclk_q <= ~bclk_q;
      end else begin
         hc <= hc + 1'b1;
      end
   end

   assign bclk_o      = bclk_q;
   assign bit_start_o = turn & bclk_q;

   // R1
   bclk_min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bclk_q) |=> $stable(bclk_q));
endmodule

// File: rtl/sbfmt_sync.sv
module sbfmt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   initial begin : p_param_chk
      assert (STAGES >= 1) else $error("STAGES must be at least 1");
   end

   generate
      if (STAGES == 1) begin : g_one
         logic r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= 1'b0;
            else        r <= d_i;
         end
         assign q_o = r;
      end else begin : g_chain
         logic [STAGES-1:0] r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= {r[STAGES-2:0], d_i};
         end
         assign q_o = r[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sbfmt_tx.sv
module sbfmt_tx
   import sbfmt_pkg::*;
#(
   parameter int CH = 4,
   parameter int AW = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_start_i,
   input  logic [1:0]       fmt_i,
   input  logic             slave_i,
   input  logic [SBW-1:0]   sb_i,
   input  logic [SBW-1:0]   rx_sb_i,
   input  logic [CH*AW-1:0] samples_i,
   output logic             sdata_o,
   output logic             fclk_o
);
   localparam int FBITS = CH * SLOT;
   localparam int BW    = $clog2(FBITS);
   localparam int SW    = BW - 5;

   initial begin : p_param_chk
      assert (CH >= 2) else $error("CH must be at least 2");
      assert (AW > 0 && AW + SBW <= SLOT) else $error("AW does not fit a slot");
   end

   logic [BW-1:0]    bitc, last, n;
   logic             wrap;
   fmt_e             fmt_l, fmt_n;
   logic [SBW-1:0]   sb_l, sb_n;
   logic [CH*AW-1:0] samp_l, samp_n;
   logic [SW-1:0]    slot;
   logic [4:0]       pos;
   logic [AW-1:0]    audio;
   logic [SLOT-1:0]  word;
   logic             lj_bit, lj_q, fclk_n;
   logic             sdata_q, fclk_q;

   always_comb begin
      last   = (fmt_l == FMT_TDM) ? BW'(FBITS - 1) : BW'(2 * SLOT - 1);
      wrap   = (bitc == last);
      n      = wrap ? '0 : bitc + 1'b1;
      fmt_n  = wrap ? fmt_e'(fmt_i) : fmt_l;
      sb_n   = wrap ? (slave_i ? rx_sb_i : sb_i) : sb_l;
      samp_n = wrap ? samples_i : samp_l;
      slot   = n[BW-1:5];
      pos    = n[4:0];
      audio  = samp_n[int'(slot) * AW +: AW];
      if (fmt_n == FMT_RJ)
         word = (SLOT'(sb_n) << (SLOT - SBW)) | SLOT'(audio);
      else
         word = (SLOT'(audio) << (SLOT - AW)) | SLOT'(sb_n);
      lj_bit = word[5'd31 - pos];
      case (fmt_n)
         FMT_I2S: fclk_n = (slot != '0);
         FMT_TDM: fclk_n = (n == '0);
         default: fclk_n = (slot == '0);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bitc    <= BW'(2 * SLOT - 1);
         fmt_l   <= FMT_LJ;
         sb_l    <= '0;
         samp_l  <= '0;
         lj_q    <= 1'b0;
         sdata_q <= 1'b0;
         fclk_q  <= 1'b0;
      end else if (bit_start_i) begin
         bitc    <= n;
         fmt_l   <= fmt_n;
         sb_l    <= sb_n;
         samp_l  <= samp_n;
         lj_q    <= lj_bit;
         sdata_q <= (fmt_n == FMT_I2S) ? lj_q : lj_bit;
         fclk_q  <= fclk_n;
      end
   end

   assign sdata_o = sdata_q;
   assign fclk_o  = fclk_q;

   // R5
   tdm_sync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_start_i && fclk_q && fmt_l == FMT_TDM) |=> !fclk_q);
endmodule

// File: rtl/sbfmt_rx.sv
module sbfmt_rx
   import sbfmt_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [1:0]     fmt_i,
   input  logic           sdata_i,
   input  logic           fclk_i,
   input  logic           bclk_i,
   output logic [SBW-1:0] sb_o,
   output logic           valid_o
);
   logic s_d, s_f, s_b;
   logic b_prev, f_prev, chg_d, locked;
   logic rise, chg, bound;
   logic [4:0]      pos, pos_n;
   logic [SLOT-2:0] sh;
   logic [SLOT-1:0] word;
   logic [SBW-1:0]  sb_q;
   logic            valid_q;

   sbfmt_sync #(.STAGES(STAGES)) i_sync_d (.clk(clk), .rst_n(rst_n), .d_i(sdata_i), .q_o(s_d));
   sbfmt_sync #(.STAGES(STAGES)) i_sync_f (.clk(clk), .rst_n(rst_n), .d_i(fclk_i),  .q_o(s_f));
   sbfmt_sync #(.STAGES(STAGES)) i_sync_b (.clk(clk), .rst_n(rst_n), .d_i(bclk_i),  .q_o(s_b));

   always_comb begin
      rise = s_b & ~b_prev;
      chg  = s_f ^ f_prev;
      case (fmt_e'(fmt_i))
         FMT_I2S: bound = chg_d;
         FMT_TDM: bound = s_f & ~f_prev;
         default: bound = chg;
      endcase
      pos_n = bound ? 5'd0 : pos + 5'd1;
      word  = {sh, s_d};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_prev  <= 1'b0;
         f_prev  <= 1'b0;
         chg_d   <= 1'b0;
         locked  <= 1'b0;
         pos     <= '0;
         sh      <= '0;
         sb_q    <= '0;
         valid_q <= 1'b0;
      end else begin
         b_prev  <= s_b;
         valid_q <= 1'b0;
         if (rise) begin
            f_prev <= s_f;
            chg_d  <= chg;
            pos    <= pos_n;
            sh     <= word[SLOT-2:0];
            if (bound) locked <= 1'b1;
            if ((locked || bound) && pos_n == 5'd31) begin
               sb_q    <= (fmt_e'(fmt_i) == FMT_RJ) ? word[SLOT-1 -: SBW] : word[SBW-1:0];
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign sb_o    = sb_q;
   assign valid_o = valid_q;

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);
endmodule

// File: rtl/sbfmt_top.sv
module sbfmt_top
   import sbfmt_pkg::*;
#(
   parameter int CH     = 4,
   parameter int AW     = 24,
   parameter int HALF   = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       fmt_i,
   input  logic             slave_i,
   input  logic [7:0]       sb_i,
   input  logic [CH*AW-1:0] samples_i,
   output logic             sdata_o,
   output logic             fclk_o,
   output logic             bclk_o,
   input  logic             rx_sdata_i,
   input  logic             rx_fclk_i,
   input  logic             rx_bclk_i,
   output logic [7:0]       rx_sb_o,
   output logic             rx_valid_o
);
   logic bit_start;

   sbfmt_bitclk #(.HALF(HALF)) i_bitclk (
      .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .bit_start_o(bit_start));

   sbfmt_tx #(.CH(CH), .AW(AW)) i_tx (
      .clk(clk), .rst_n(rst_n), .bit_start_i(bit_start), .fmt_i(fmt_i),
      .slave_i(slave_i), .sb_i(sb_i), .rx_sb_i(rx_sb_o), .samples_i(samples_i),
      .sdata_o(sdata_o), .fclk_o(fclk_o));

   sbfmt_rx #(.STAGES(STAGES)) i_rx (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .sdata_i(rx_sdata_i),
      .fclk_i(rx_fclk_i), .bclk_i(rx_bclk_i), .sb_o(rx_sb_o), .valid_o(rx_valid_o));

   // R1
   sdata_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdata_o) |-> $fell(bclk_o));

   // R1
   fclk_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fclk_o) |-> $fell(bclk_o));
endmodule

// File: tb/test_sbfmt_top.sv
module test_sbfmt_top;
   localparam int CLK_PERIOD = 10;
   localparam int CH = 4;
   localparam int AW = 24;
   localparam int HALF = 2;
   localparam int NV = 7;
   localparam int MAXB = CH * 32;

   // fmt, sideband, ch0, ch1, ch2, ch3
   localparam logic [105:0] VEC [NV] = '{
      {2'd0, 8'hA5, 24'hC0FFEE, 24'h135724, 24'h000000, 24'h000000},
      {2'd1, 8'h3C, 24'h800001, 24'h7FFFFE, 24'h000000, 24'h000000},
      {2'd2, 8'h96, 24'h0F1E2D, 24'hF0E1D2, 24'h000000, 24'h000000},
      {2'd3, 8'h5A, 24'h111111, 24'h222222, 24'h333333, 24'h444444},
      {2'd2, 8'h01, 24'hFFFFFF, 24'h000000, 24'h000000, 24'h000000},
      {2'd3, 8'hFE, 24'hA0A0A0, 24'h0B0B0B, 24'hC0C0C1, 24'h0D0D0D},
      {2'd1, 8'h00, 24'hABCD12, 24'h654321, 24'h000000, 24'h000000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] fmt = 2'd0;
   logic slave = 1'b0;
   logic [7:0] sb = 8'h00;
   logic [7:0] src_sb = 8'h00;
   logic [CH*AW-1:0] samples = '0;

   logic sdata, fclk, bclk, rx_valid;
   logic [7:0] rx_sb;
   logic src_sdata, src_fclk, src_bclk, src_rx_valid;
   logic [7:0] src_rx_sb;

   int checks = 0;
   int errors = 0;
   int pulses = 0;
   bit done = 1'b0;
   logic cap_d [0:MAXB];
   logic cap_f [0:MAXB];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sbfmt_top #(.CH(CH), .AW(AW), .HALF(HALF), .STAGES(2)) i_src (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .slave_i(1'b0), .sb_i(src_sb),
      .samples_i(samples), .sdata_o(src_sdata), .fclk_o(src_fclk), .bclk_o(src_bclk),
      .rx_sdata_i(1'b0), .rx_fclk_i(1'b0), .rx_bclk_i(1'b0),
      .rx_sb_o(src_rx_sb), .rx_valid_o(src_rx_valid));

   sbfmt_top #(.CH(CH), .AW(AW), .HALF(HALF), .STAGES(2)) i_sbfmt_top (
      .clk(clk), .rst_n(rst_n), .fmt_i(fmt), .slave_i(slave), .sb_i(sb),
      .samples_i(samples), .sdata_o(sdata), .fclk_o(fclk), .bclk_o(bclk),
      .rx_sdata_i(src_sdata), .rx_fclk_i(src_fclk), .rx_bclk_i(src_bclk),
      .rx_sb_o(rx_sb), .rx_valid_o(rx_valid));

   always @(negedge clk) if (rx_valid === 1'b1) pulses++;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic get_bit(output logic d, output logic f);
      while (bclk !== 1'b0) @(negedge clk);
      while (bclk !== 1'b1) @(negedge clk);
      d = sdata;
      f = fclk;
   endtask

   task automatic find_frame(input logic [1:0] fm);
      logic d, f, pf;
      bit hit;
      get_bit(d, pf);
      hit = 1'b0;
      while (!hit) begin
         get_bit(d, f);
         hit = (fm == 2'd1) ? (pf && !f) : (!pf && f);
         pf = f;
      end
      cap_d[0] = d;
      cap_f[0] = f;
      pulses = 0;
   endtask

   function automatic int nbits(input logic [1:0] fm);
      return (fm == 2'd3) ? CH * 32 : 64;
   endfunction

   task automatic capture(input logic [1:0] fm);
      for (int i = 1; i <= nbits(fm); i++) get_bit(cap_d[i], cap_f[i]);
   endtask

   function automatic logic [31:0] expw(input logic [1:0] fm, input logic [7:0] s,
                                        input logic [23:0] a);
      return (fm == 2'd2) ? {s, a} : {a, s};
   endfunction

   task automatic check_frame(input logic [1:0] fm, input logic [7:0] sbv,
                              input logic [CH*AW-1:0] smp, input string req);
      int nb, nsl, off, bad;
      logic [31:0] w;
      logic ef;
      nb  = nbits(fm);
      nsl = nb / 32;
      off = (fm == 2'd1) ? 1 : 0;
      for (int s = 0; s < nsl; s++) begin
         for (int p = 0; p < 32; p++) w[31 - p] = cap_d[s * 32 + p + off];
         chk(w == expw(fm, sbv, smp[s * AW +: AW]), req, $sformatf("slot %0d word", s),
             64'(w), 64'(expw(fm, sbv, smp[s * AW +: AW])));
      end
      bad = 0;
      for (int i = 0; i < nb; i++) begin
         case (fm)
            2'd1:    ef = (i >= 32);
            2'd3:    ef = (i == 0);
            default: ef = (i < 32);
         endcase
         if (cap_f[i] !== ef) bad++;
      end
      chk(bad == 0, req, "frame clock pattern mismatches", 64'(bad), 64'd0);
      // R1: next frame begins exactly nb bits later
      if (fm == 2'd1)
         chk(cap_f[nb - 1] === 1'b1 && cap_f[nb] === 1'b0, "R1", "frame length",
             {62'd0, cap_f[nb - 1], cap_f[nb]}, 64'd2);
      else
         chk(cap_f[nb - 1] === 1'b0 && cap_f[nb] === 1'b1, "R1", "frame length",
             {62'd0, cap_f[nb - 1], cap_f[nb]}, 64'd1);
   endtask

   task automatic check_rx(input logic [1:0] fm, input logic [7:0] sbv);
      int exp_p;
      repeat (12) @(negedge clk);
      exp_p = nbits(fm) / 32 + ((fm == 2'd1) ? 1 : 0);
      chk(rx_sb === sbv, "R8", "received sideband", 64'(rx_sb), 64'(sbv));
      chk(pulses == exp_p, "R8", "valid strobe count", 64'(pulses), 64'(exp_p));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [1:0] fm;
      logic [7:0] sv;
      logic [CH*AW-1:0] smp;
      int t0, t1;

      // R9: reset state
      repeat (5) @(negedge clk);
      chk(sdata === 1'b0 && fclk === 1'b0 && bclk === 1'b0, "R9", "serial outputs in reset",
          {61'd0, sdata, fclk, bclk}, 64'd0);
      chk(rx_valid === 1'b0 && rx_sb === 8'h00, "R9", "receiver outputs in reset",
          {55'd0, rx_valid, rx_sb}, 64'd0);
      rst_n = 1'b1;

      // R1: bit clock period is 2*HALF system clocks
      while (bclk !== 1'b1) @(negedge clk);
      t0 = 0;
      while (bclk !== 1'b0) begin @(negedge clk); t0++; end
      t1 = 0;
      while (bclk !== 1'b1) begin @(negedge clk); t1++; end
      chk(t0 == HALF && t1 == HALF, "R1", "bit clock half periods",
          64'(t0 * 16 + t1), 64'(HALF * 16 + HALF));

      // table walk: R2 LJ, R3 I2S, R4 RJ, R5 TDM, R8 receiver
      for (int v = 0; v < NV; v++) begin
         fm  = VEC[v][105:104];
         sv  = VEC[v][103:96];
         smp = {VEC[v][23:0], VEC[v][47:24], VEC[v][71:48], VEC[v][95:72]};
         fmt = fm; sb = sv; src_sb = sv; samples = smp;
         repeat (3) find_frame(fm);
         capture(fm);
         case (fm)
            2'd0:    check_frame(fm, sv, smp, "R2");
            2'd1:    check_frame(fm, sv, smp, "R3");
            2'd2:    check_frame(fm, sv, smp, "R4");
            default: check_frame(fm, sv, smp, "R5");
         endcase
         check_rx(fm, sv);
      end

      // R6: inputs changed just after the frame starts do not affect it
      fmt = 2'd0; sb = 8'h6B; src_sb = 8'h6B;
      smp = {24'h0, 24'h0, 24'h2468AC, 24'hFEDCBA};
      samples = smp;
      repeat (3) find_frame(2'd0);
      sb = 8'h94; src_sb = 8'h94; samples = ~smp; fmt = 2'd2;
      capture(2'd0);
      check_frame(2'd0, 8'h6B, smp, "R6");

      // R7: follower forwards received byte and ignores sb_i
      fmt = 2'd2; slave = 1'b1; sb = 8'h11; src_sb = 8'hC3;
      smp = {24'h0, 24'h0, 24'h00FF00, 24'h5500AA};
      samples = smp;
      repeat (4) find_frame(2'd2);
      capture(2'd2);
      check_frame(2'd2, 8'hC3, smp, "R7");
      check_rx(2'd2, 8'hC3);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule